// File: doc/BRIEF.md
# Pad Configuration Chain Stage

This block is one link in a daisy chain of configuration registers, one link per I/O pad. A loader drives three slow lines to every link at once: a serial clock, an active-low strobe and serial data. Each link keeps a 13-bit shift register and a separate active configuration word. The shift register's top bit goes on to the next link, so that a run of words, one per pad, can be pushed through the whole chain. No word has to be addressed on its own.

The shifted words take effect only on a commit. The loader holds the serial clock high after the last shift and pulses the strobe low. A strobe pulse while the serial clock is low, or a global reset, puts the power-up word back instead. The power-up word depends on where the pad sits: bidirectional (0x1803) for the first two pads and plain input (0x0403) for the rest. The link decodes two fields of the active word as outputs of their own. The output-enable-bar flag lets the core see when a pad has been taken over as an extra output.

The three serial lines are oversampled by the block clock. The loader holds each level for at least two block clock cycles.

Top module: `pad_cfg_stage`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `cfg_o` becomes the default word: 0x1803 when `BIDIR_DEFAULT` is 1, 0x0403 when it is 0.
- R2: A low-to-high change of `ser_clk_i` while `ser_rstn_i` is high shifts the shift register left by one place and takes `ser_data_i` into bit 0. `ser_data_o` is bit 12 of the shift register, so words arrive most significant bit first.
- R3: Shifting leaves `cfg_o` unchanged. `cfg_o` changes only while `ser_rstn_i` is low or `rst_n` is low.
- R4: When `ser_rstn_i` is low while `ser_clk_i` is high, the shift register contents are copied into `cfg_o`.
- R5: When `ser_rstn_i` is low while `ser_clk_i` is low, `cfg_o` returns to the default word.
- R6: `oe_n_o` shows bit 1 of `cfg_o`, and `in_dis_o` shows bit 3 of `cfg_o`.
- R7: In a chain of N links, the loader sends N words of 13 bits each, highest pad first, with no gap bits between them. After a commit, link k holds the k-th word.
- R8: A high-to-low change of `ser_clk_i` does not shift. `ser_data_o` holds its value across it, whatever `ser_data_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial lines |
| rst_n | input | 1 | Synchronous active-low global reset |
| ser_clk_i | input | 1 | Serial clock from the loader |
| ser_rstn_i | input | 1 | Active-low strobe: commit (clock high) or restore default (clock low) |
| ser_data_i | input | 1 | Serial data from the loader or the previous link |
| ser_data_o | output | 1 | Top bit of the shift register, to the next link |
| cfg_o | output | 13 | Active configuration word |
| oe_n_o | output | 1 | Output-enable-bar field of the active word |
| in_dis_o | output | 1 | Input-disable field of the active word |

## Verification
The assertions assume that the loader changes the serial lines only between block clock edges. They also assume that each level stays put for at least two block cycles, so that every serial clock edge is seen as exactly one change of the sampled level. The bench drives all lines on the falling edge of `clk` and holds every phase for two cycles. Data changes only while the serial clock is low, and the strobe is pulsed only after the serial clock has settled. Under those conditions the assertions check several rules together. A strobe held high freezes the active word. A strobe low with the serial clock low forces the default word. The serial output does not move while the serial clock is low. The decoded flags move only with the active word.

// File: rtl/pcs_pkg.sv
// Shared constants for the pad configuration chain.
// Assumes a 13-bit control word with fixed flag positions.
package pcs_pkg;
    localparam int CFG_W = 13;
    localparam logic [CFG_W-1:0] WORD_BIDIR = 13'h1803;
    localparam logic [CFG_W-1:0] WORD_INPUT = 13'h0403;
    localparam int POS_OEB   = 1;
    localparam int POS_INDIS = 3;
endpackage

// File: rtl/pcs_line_sense.sv
// Turns the oversampled serial clock and strobe into one-cycle actions.
// Assumes the serial lines are steady around clk edges and each level
// is held for at least two clk cycles.
module pcs_line_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk_i,
    input  logic ser_rstn_i,
    output logic shift_en,
    output logic commit_en,
    output logic restore_en
);
    logic sclk_q;

    // Remember the previous serial clock level; idle high so release is no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b1;
        else        sclk_q <= ser_clk_i;
    end

    // Decode a rising edge, a commit strobe and a restore strobe.
    always_comb begin
        shift_en   = ser_clk_i && !sclk_q && ser_rstn_i;
        commit_en  = !ser_rstn_i && ser_clk_i;
        restore_en = !ser_rstn_i && !ser_clk_i;
    end
endmodule

// File: rtl/pcs_shift_reg.sv
// Serial-in shift register, most significant bit leaves first.
// Assumes shift_en is a single-cycle pulse per serial clock rise.
module pcs_shift_reg #(
    parameter int W = pcs_pkg::CFG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q,
    output logic         dout
);
    // Shift left, new bit into the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[W-2:0], din};
    end

    // Top bit feeds the next link.
    always_comb dout = q[W-1];
endmodule

// File: rtl/pcs_active_reg.sv
// Active configuration word with commit and restore-default paths.
// Assumes commit_en and restore_en are never high together.
module pcs_active_reg #(
    parameter int W = pcs_pkg::CFG_W,
    parameter logic [W-1:0] DEF = pcs_pkg::WORD_INPUT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit_en,
    input  logic         restore_en,
    input  logic [W-1:0] shadow,
    output logic [W-1:0] q
);
    // Reset/restore to the default, commit copies the shadow word.
    always_ff @(posedge clk) begin
        if (!rst_n)          q <= DEF;
        else if (restore_en) q <= DEF;
        else if (commit_en)  q <= shadow;
    end
endmodule

// File: rtl/pad_cfg_stage.sv
// One link of the pad configuration chain: shift register, active word
// and decoded flags. Assumes slow serial lines sampled by clk.
module pad_cfg_stage #(
    parameter int W = pcs_pkg::CFG_W,
    parameter bit BIDIR_DEFAULT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_clk_i,
    input  logic         ser_rstn_i,
    input  logic         ser_data_i,
    output logic         ser_data_o,
    output logic [W-1:0] cfg_o,
    output logic         oe_n_o,
    output logic         in_dis_o
);
    localparam logic [W-1:0] DEF_WORD =
        BIDIR_DEFAULT ? W'(pcs_pkg::WORD_BIDIR) : W'(pcs_pkg::WORD_INPUT);

    logic         shift_en, commit_en, restore_en;
    logic [W-1:0] shadow;

    pcs_line_sense sense_i (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk_i), .ser_rstn_i(ser_rstn_i),
        .shift_en(shift_en), .commit_en(commit_en), .restore_en(restore_en)
    );

    pcs_shift_reg #(.W(W)) shift_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .din(ser_data_i), .q(shadow), .dout(ser_data_o)
    );

    pcs_active_reg #(.W(W), .DEF(DEF_WORD)) active_i (
        .clk(clk), .rst_n(rst_n), .commit_en(commit_en),
        .restore_en(restore_en), .shadow(shadow), .q(cfg_o)
    );

    // Pull the two flag fields out of the active word.
    always_comb begin
        oe_n_o   = cfg_o[pcs_pkg::POS_OEB];
        in_dis_o = cfg_o[pcs_pkg::POS_INDIS];
    end
endmodule

// File: rtl/pad_cfg_stage_chk.sv
// Port-level checks for one chain link, bound to pad_cfg_stage.
module pad_cfg_stage_chk #(
    parameter int W = 13,
    parameter logic [W-1:0] DEF = 13'h0403
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ser_clk_i,
    input logic         ser_rstn_i,
    input logic         ser_data_o,
    input logic [W-1:0] cfg_o,
    input logic         oe_n_o,
    input logic         in_dis_o
);
    assert_reset_default_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_o == DEF);

    assert_hold_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ser_rstn_i) |=> $stable(cfg_o));

    assert_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !ser_rstn_i && !ser_clk_i) |=> cfg_o == DEF);

    assert_flag_oeb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe_n_o) |-> !$stable(cfg_o));

    assert_flag_indis_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_dis_o) |-> !$stable(cfg_o));

    assert_no_fall_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !ser_clk_i) |=> $stable(ser_data_o));
endmodule

bind pad_cfg_stage pad_cfg_stage_chk #(.W(W), .DEF(DEF_WORD)) chk_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i), .ser_rstn_i(ser_rstn_i),
    .ser_data_o(ser_data_o), .cfg_o(cfg_o), .oe_n_o(oe_n_o), .in_dis_o(in_dis_o)
);

// File: tb/pad_cfg_stage_tb_top.sv
// Chains four links and sweeps word patterns through them.
module pad_cfg_stage_tb_top;
    localparam int N = 4;
    localparam int W = 13;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, sclk, srstn, sdat;
    logic [N:0]   chain;
    logic [W-1:0] cfg [N];
    logic [N-1:0] oen, indis;

    assign chain[0] = sdat;

    for (genvar k = 0; k < N; k++) begin : stg
        pad_cfg_stage #(.W(W), .BIDIR_DEFAULT(k < 2)) dut_i (
            .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_rstn_i(srstn),
            .ser_data_i(chain[k]), .ser_data_o(chain[k+1]),
            .cfg_o(cfg[k]), .oe_n_o(oen[k]), .in_dis_o(indis[k])
        );
    end

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [W-1:0] word [N];
    logic [W-1:0] live [N];

    function automatic logic [W-1:0] defw(int k);
        return (k < 2) ? 13'h1803 : 13'h0403;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sclk = 1'b0; sdat = b; wait_n(2);
        sclk = 1'b1; wait_n(2);
    endtask

    task automatic load_words();
        for (int p = N - 1; p >= 0; p--)
            for (int b = W - 1; b >= 0; b--)
                send_bit(word[p][b]);
    endtask

    task automatic commit();
        srstn = 1'b0; wait_n(2);
        srstn = 1'b1; wait_n(2);
        sclk  = 1'b0; wait_n(2);
    endtask

    task automatic check_live(input string req);
        for (int k = 0; k < N; k++) begin
            chk(cfg[k] === live[k], req, 32'(cfg[k]), 32'(live[k]));
            chk(oen[k] === live[k][1], {req, " R6 oeb"}, 32'(oen[k]), 32'(live[k][1]));
            chk(indis[k] === live[k][3], {req, " R6 indis"}, 32'(indis[k]), 32'(live[k][3]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sclk = 1'b0; srstn = 1'b1; sdat = 1'b0;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        for (int k = 0; k < N; k++) live[k] = defw(k);
        check_live("R1 reset");

        for (int r = 0; r < 18; r++) begin
            for (int k = 0; k < N; k++) begin
                if (r < 13)       word[k] = W'(1) << ((r + k) % W);
                else if (r == 13) word[k] = '1;
                else if (r == 14) word[k] = '0;
                else              word[k] = W'(r * 1237 + k * 421 + 32'h5A5);
            end
            load_words();
            check_live("R3 shift keeps word");
            for (int k = 0; k < N; k++)
                chk(chain[k+1] === word[k][W-1], "R2 top bit out", 32'(chain[k+1]), 32'(word[k][W-1]));
            commit();
            for (int k = 0; k < N; k++) live[k] = word[k];
            check_live("R4 R7 commit");
            sdat = ~sdat; wait_n(3);
            for (int k = 0; k < N; k++)
                chk(chain[k+1] === word[k][W-1], "R8 fall no shift", 32'(chain[k+1]), 32'(word[k][W-1]));
            if (r == 5 || r == 16) begin
                srstn = 1'b0; wait_n(2);
                srstn = 1'b1; wait_n(2);
                for (int k = 0; k < N; k++) live[k] = defw(k);
                check_live("R5 restore");
            end
            if (r == 10) begin
                rst_n = 1'b0; wait_n(2);
                rst_n = 1'b1; wait_n(1);
                for (int k = 0; k < N; k++) live[k] = defw(k);
                check_live("R1 mid reset");
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule